// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block generates a system reset from two sources. One is a supply-good flag that comes from an external voltage comparator. The other is an active-low manual-reset pin. Both inputs are asynchronous to the block's clock. Each one passes through a synchronizer and then through a level qualification filter before the central state machine sees it.

Reset is held while the qualified supply flag reports undervoltage. After the supply recovers, reset stays asserted for one full timeout. A manual request starts only on a falling edge of the debounced pin. It produces exactly one pulse of the same timeout length, and the pulse cannot be retriggered. After the pulse the pin is ignored for a lockout window. Once the lockout has ended, the pin must be seen high before a new falling edge can be accepted. All durations are parameters counted in clock cycles. The defaults assume a 250 MHz clock:

| Duration | Default cycles | Real time |
|---|---|---|
| Timeout | 350,000,000 | 1.4 s |
| Lockout | 21,250 | 85 µs |
| Pin debounce | 500 | 2 µs |
| Supply qualification | 5,000 | 20 µs |

The state machine has five states:
- **ST_SUPPLY_HOLD** (reset asserted) is the state after power-up. It counts the timeout while the supply is good.
- **ST_IDLE** (released) waits for a request.
- **ST_MR_PULSE** (asserted) times the manual pulse.
- **ST_MR_LOCKOUT** (released) times the lockout window.
- **ST_WAIT_HIGH** (released) waits for the pin to return high.

Transitions:
- Supply bad in any state → ST_SUPPLY_HOLD, with the counter cleared.
- Timeout done in ST_SUPPLY_HOLD → ST_IDLE.
- Pin falling edge in ST_IDLE → ST_MR_PULSE.
- Timeout done in ST_MR_PULSE → ST_MR_LOCKOUT.
- Lockout done → ST_IDLE if the pin is high, otherwise → ST_WAIT_HIGH.
- Pin high in ST_WAIT_HIGH → ST_IDLE.

Top module: `supv_reset_ctrl`

## Requirements
- R1: After the asynchronous reset, the output is asserted. It stays asserted until the qualified supply flag is good and a full timeout has elapsed.
- R2: A qualified supply-bad level asserts the output on the clock edge that follows, in every state.
- R3: After the qualified supply flag returns good, the output stays asserted for exactly TMO_CYC cycles and then releases. It never releases while the flag is bad.
- R4: Each input passes through a synchronizer of SYNC_STAGES flops. A supply-bad level must persist for SUP_QUAL_CYC consecutive cycles before it counts, so shorter dips have no effect on the output.
- R5: A low level on the manual pin must persist for MR_DEB_CYC consecutive cycles before it counts, so shorter glitches have no effect on the output.
- R6: A manual reset starts only on a high-to-low change of the debounced pin (pin value 0 means request). A pin that is held low from power-up never starts one.
- R7: A manual request produces exactly one asserted pulse of TMO_CYC cycles. Further edges during the pulse do not extend or repeat it.
- R8: For LOCK_CYC cycles after a manual pulse ends, the pin is ignored and the output stays released.
- R9: If the pin is still low when the lockout ends, no reset starts. The pin must be seen high and then fall again.
- R10: A supply failure during a manual pulse or a lockout takes priority. The output then releases TMO_CYC cycles after the supply recovers.
- R11: With ACTIVE_LOW = 1 the output is 0 while reset is asserted. With ACTIVE_LOW = 0 it is 1 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Comparator flag, 1 = supply above threshold |
| mr_n_i | input | 1 | Manual reset pin, active low |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_LOW |

## Verification
Every state decides directly whether reset is asserted. A wrong state therefore shows at the output pin one cycle after the faulty transition. A wrong timer count shows at the end of a pulse or a hold, as a release that comes early or late. A wrong lockout count or a wrong pin-high test stays hidden until the next pin activity. It then shows as a pulse that should not happen, or as a missing pulse, a few filter cycles later. For these reasons the bench compares the pin with a cycle-accurate model on every clock, and drives edges inside the pulse and inside the lockout window.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_SUPPLY_HOLD = 3'd1,
        ST_MR_PULSE    = 3'd2,
        ST_MR_LOCKOUT  = 3'd3,
        ST_WAIT_HIGH   = 3'd4
    } supv_state_e;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d};
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/supv_filter.sv
// Output follows the input only after the input has differed from it
// for HOLD_CYC consecutive clock cycles.
module supv_filter #(
    parameter int   HOLD_CYC = 4,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
            lvl_q <= RST_VAL;
        end else if (d == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_q <= d;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign q = lvl_q;
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
    parameter int TMO_CYC      = 350_000_000,
    parameter int LOCK_CYC     = 21_250,
    parameter int MR_DEB_CYC   = 500,
    parameter int SUP_QUAL_CYC = 5_000,
    parameter int SYNC_STAGES  = 2,
    parameter bit ACTIVE_LOW   = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok_i,
    input  logic mr_n_i,
    output logic sys_rst_o
);
    import supv_pkg::*;

    localparam int MAXC = (TMO_CYC > LOCK_CYC) ? TMO_CYC : LOCK_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_CYC - 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

    logic sup_s, mr_s, sup_f, mr_f;
    logic mr_prev_q, mr_fall, rst_act;
    supv_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sup_sync (
        .clk(clk), .arst_n(arst_n), .d(supply_ok_i), .q(sup_s));
    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .arst_n(arst_n), .d(mr_n_i), .q(mr_s));

    supv_filter #(.HOLD_CYC(SUP_QUAL_CYC), .RST_VAL(1'b0)) u_sup_filt (
        .clk(clk), .arst_n(arst_n), .d(sup_s), .q(sup_f));
    supv_filter #(.HOLD_CYC(MR_DEB_CYC), .RST_VAL(1'b1)) u_mr_filt (
        .clk(clk), .arst_n(arst_n), .d(mr_s), .q(mr_f));

    assign mr_fall = mr_prev_q & ~mr_f;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q   <= ST_SUPPLY_HOLD;
            cnt_q     <= '0;
            mr_prev_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            mr_prev_q <= mr_f;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!sup_f) begin
            state_d = ST_SUPPLY_HOLD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_SUPPLY_HOLD: begin
                    if (cnt_q == TMO_LAST) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    cnt_d = '0;
                    if (mr_fall) state_d = ST_MR_PULSE;
                end
                ST_MR_PULSE: begin
                    if (cnt_q == TMO_LAST) begin
                        state_d = ST_MR_LOCKOUT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_MR_LOCKOUT: begin
                    if (cnt_q == LOCK_LAST) begin
                        state_d = mr_f ? ST_IDLE : ST_WAIT_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WAIT_HIGH: begin
                    cnt_d = '0;
                    if (mr_f) state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_SUPPLY_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        rst_act = (state_q == ST_SUPPLY_HOLD) || (state_q == ST_MR_PULSE);
    end

    generate
        if (ACTIVE_LOW) begin : g_out_low
            assign sys_rst_o = ~rst_act;
        end else begin : g_out_high
            assign sys_rst_o = rst_act;
        end
    endgenerate
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int CW   = 8,
    parameter int MAXC = 100
) (
    input logic          clk,
    input logic          arst_n,
    input logic          sup_f,
    input logic          mr_f,
    input logic          mr_prev_q,
    input logic          rst_act,
    input logic [2:0]    state_q,
    input logic [CW-1:0] cnt_q
);
    import supv_pkg::*;

    // R2
    sup_low_asserts_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !sup_f |=> rst_act);

    // R6
    start_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_act) |-> ($past(!sup_f) || $past(mr_prev_q && !mr_f)));

    // R3
    release_needs_supply_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_act) |-> $past(sup_f));

    // R8
    lockout_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == 3'(ST_MR_LOCKOUT) && sup_f) |=> !rst_act);

    // R9
    wait_high_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == 3'(ST_WAIT_HIGH) && sup_f) |=> !rst_act);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= CW'(MAXC - 1));
endmodule

bind supv_reset_ctrl supv_reset_chk #(.CW(CW), .MAXC(MAXC)) u_chk (
    .clk(clk), .arst_n(arst_n), .sup_f(sup_f), .mr_f(mr_f),
    .mr_prev_q(mr_prev_q), .rst_act(rst_act), .state_q(state_q), .cnt_q(cnt_q));

// File: tb/supv_reset_ctrl_bench.sv
`timescale 1ns/1ps
module supv_reset_ctrl_bench;
    localparam int TMO  = 40;
    localparam int LOCK = 12;
    localparam int DEB  = 4;
    localparam int QUAL = 6;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic sup_in = 1'b0;
    logic mr_in = 1'b0;
    logic rst_lo, rst_hi;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    supv_reset_ctrl #(.TMO_CYC(TMO), .LOCK_CYC(LOCK), .MR_DEB_CYC(DEB),
        .SUP_QUAL_CYC(QUAL), .SYNC_STAGES(2), .ACTIVE_LOW(1'b1)) u_supv_reset_ctrl (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(sup_in), .mr_n_i(mr_in),
        .sys_rst_o(rst_lo));

    supv_reset_ctrl #(.TMO_CYC(TMO), .LOCK_CYC(LOCK), .MR_DEB_CYC(DEB),
        .SUP_QUAL_CYC(QUAL), .SYNC_STAGES(2), .ACTIVE_LOW(1'b0)) u_supv_reset_ctrl_hi (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(sup_in), .mr_n_i(mr_in),
        .sys_rst_o(rst_hi));

    // Behavioural reference: mode 0 released idle, 1 supply hold, 2 pulse,
    // 3 lockout, 4 waiting for the pin to be high.
    int ss1, ss2, ms1, ms2, sf, sc, mf, mc, mp, md, tc;

    always @(posedge clk) begin
        if (!arst_n) begin
            ss1 = 0; ss2 = 0; ms1 = 1; ms2 = 1;
            sf = 0; sc = 0; mf = 1; mc = 0; mp = 1; md = 1; tc = 0;
        end else begin
            if (sf == 0) begin md = 1; tc = 0; end
            else case (md)
                1: if (tc == TMO - 1) begin md = 0; tc = 0; end else tc++;
                0: if (mp == 1 && mf == 0) md = 2;
                2: if (tc == TMO - 1) begin md = 3; tc = 0; end else tc++;
                3: if (tc == LOCK - 1) begin md = (mf == 1) ? 0 : 4; tc = 0; end else tc++;
                4: if (mf == 1) md = 0;
                default: md = 1;
            endcase
            mp = mf;
            if (ss2 == sf) sc = 0;
            else if (sc == QUAL - 1) begin sf = ss2; sc = 0; end
            else sc++;
            if (ms2 == mf) mc = 0;
            else if (mc == DEB - 1) begin mf = ms2; mc = 0; end
            else mc++;
            ss2 = ss1; ss1 = int'(sup_in);
            ms2 = ms1; ms1 = int'(mr_in);
        end
    end

    // Compare both polarities on every clock (R11 and the active scenario tag)
    always @(negedge clk) begin
        if (arst_n && !done) begin
            logic exp_act;
            exp_act = (md == 1 || md == 2);
            checks++;
            if (rst_lo !== ~exp_act || rst_hi !== exp_act) begin
                errors++;
                $display("FAIL %s/R11 cycle compare: lo=%b hi=%b expected act=%b",
                         tag, rst_lo, rst_hi, exp_act);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spot(input string rq, input bit exp_act);
        checks++;
        if (rst_hi !== exp_act || rst_lo !== ~exp_act) begin
            errors++;
            $display("FAIL %s spot: hi=%b lo=%b expected act=%b", rq, rst_hi, rst_lo, exp_act);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        spot("R1", 1'b1);
        arst_n = 1'b1;
        step(20);
        spot("R1", 1'b1);
        tag = "R3";
        sup_in = 1'b1;
        step(30);
        spot("R3", 1'b1);
        step(40);
        spot("R3", 1'b0);
        tag = "R6";
        step(10);
        spot("R6", 1'b0);
        mr_in = 1'b1;
        step(20);
        spot("R6", 1'b0);
        tag = "R5";
        mr_in = 1'b0; step(2); mr_in = 1'b1;
        step(20);
        spot("R5", 1'b0);
        tag = "R4";
        sup_in = 1'b0; step(3); sup_in = 1'b1;
        step(20);
        spot("R4", 1'b0);
        tag = "R7";
        mr_in = 1'b0; step(8); mr_in = 1'b1;
        step(4);
        spot("R7", 1'b1);
        step(8);
        mr_in = 1'b0; step(8); mr_in = 1'b1;
        step(2);
        mr_in = 1'b0; step(6); mr_in = 1'b1;
        step(8);
        spot("R7", 1'b1);
        tag = "R8";
        step(6);
        mr_in = 1'b0; step(2);
        spot("R7", 1'b0);
        step(4); mr_in = 1'b1;
        step(14);
        spot("R8", 1'b0);
        step(20);
        tag = "R9";
        mr_in = 1'b0;
        step(90);
        spot("R9", 1'b0);
        step(10);
        mr_in = 1'b1;
        step(20);
        mr_in = 1'b0;
        step(12);
        spot("R9", 1'b1);
        mr_in = 1'b1;
        step(80);
        tag = "R10";
        mr_in = 1'b0; step(8); mr_in = 1'b1;
        step(12);
        sup_in = 1'b0; step(10); sup_in = 1'b1;
        step(30);
        spot("R10", 1'b1);
        step(30);
        spot("R10", 1'b0);
        tag = "R2";
        sup_in = 1'b0;
        step(12);
        spot("R2", 1'b1);
        step(8);
        sup_in = 1'b1;
        step(60);
        spot("R2", 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule